// File: doc/BRIEF.md
# Interpolating Pulse-Width Timer Back End

This block measures how long a pulse lasts, to a fraction of a clock period. A coarse counter in the system clock domain counts the clock cycles in which the pulse gate is sampled high. At each pulse edge, an external tapped delay chain is frozen into a register and presented as a thermometer-coded snapshot. The block turns each snapshot into a count of filled taps. There is one snapshot bus for the leading edge and one for the trailing edge.

Delay cells drift with supply and temperature, so a fixed delay per tap cannot be assumed. A calibration strobe makes the block capture, once per edge path, how many taps fill within one clock period. A measurement strobe then starts a sequential divider. The divider works out each edge fraction as taps over taps-per-period, with 8 fractional bits. The block outputs coarse count plus leading fraction minus trailing fraction as unsigned fixed point, with a single-cycle valid pulse. If a calibrated period is zero, the block raises an error flag and produces no result.

Top module: `interval_tdc`

## Requirements
- R1: After reset, `busy`, `cal_error` and `result_valid` are 0, `result` is 0, and both calibrated periods are 0.
- R2: A snapshot decodes to the number of consecutive 1s counted upward from bit 0, which is the tap nearest the injected edge. Every bit above the first 0 is ignored. An all-ones snapshot decodes to TAPS.
- R3: The coarse count equals the number of rising clock edges at which `gate` is sampled high, counted from the sample where it rises. It saturates at 2^CW-1.
- R4: The leading tap count is taken from `lead_taps` at the first edge where `gate` is sampled high. The trailing tap count is taken from `trail_taps` at the first edge where `gate` is sampled low again.
- R5: When the block is idle, a `cal_start` sampled at edge k is accepted. The leading period is taken from `lead_taps` at edge k+1 and the trailing period from `trail_taps` at edge k+2. `busy` is 1 between those edges.
- R6: `result` = coarse·256 + floor(lead·256/lead_period) − floor(trail·256/trail_period), clamped to 0 when negative and to 2^(CW+8)−1 when too large.
- R7: `result_valid` is high for exactly one cycle per measurement, and `result` holds its value until the next one.
- R8: When idle, a `coarse_done` is accepted. If either calibrated period is 0 at that point, `cal_error` goes to 1 after that edge and no `result_valid` follows. `cal_error` clears when the next strobe is accepted.
- R9: `cal_start` and `coarse_done` are ignored while `busy` is 1. If both arrive in the same idle cycle, calibration runs and the measurement request is dropped.
- R10: `busy` is 1 from the edge that accepts a valid measurement until the edge that raises `result_valid`, and 0 in the cycle where `result_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_start | input | 1 | Request a per-edge taps-per-period calibration |
| gate | input | 1 | Pulse gate; the coarse counter runs while it is high |
| coarse_done | input | 1 | Request the fixed-point result for the last pulse |
| lead_taps | input | TAPS | Registered delay-chain snapshot for the leading edge |
| trail_taps | input | TAPS | Registered delay-chain snapshot for the trailing edge |
| busy | output | 1 | Calibration or division in progress |
| cal_error | output | 1 | Last measurement request found a zero calibrated period |
| result | output | CW+8 | Pulse width in clock periods, 8 fractional bits |
| result_valid | output | 1 | One-cycle strobe marking a new `result` |

## Verification
Calibration and a measurement request can arrive in the same idle cycle. The bench raises `cal_start` and `coarse_done` on one edge with new tap counts on the buses. It then watches for 60 cycles to confirm that no result appears. Next it runs a full pulse and checks that the result uses the new periods. A second test raises both strobes in the middle of a division with an all-zero snapshot. The result of that division must come out unchanged, and the next result must still use the old periods.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAL_L,
    ST_CAL_T,
    ST_DIV_L,
    ST_DIV_T
  } tdc_state_t;
endpackage

// File: rtl/therm_count.sv
module therm_count #(
  parameter int TAPS = 16,
  localparam int TW = $clog2(TAPS + 1)
) (
  input  logic [TAPS-1:0] taps,
  output logic [TW-1:0]   count
);
  logic [TAPS-1:0] run;

  assign run[0] = taps[0];
  for (genvar i = 1; i < TAPS; i++) begin : g_run
    assign run[i] = run[i-1] & taps[i];
  end

  always_comb begin
    count = '0;
    for (int k = 0; k < TAPS; k++) count = count + TW'(run[k]);
  end

  always_comb begin
    if (int'(count) < TAPS)
      assert_first_zero_R2: assert (taps[count] == 1'b0);
  end
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int NW = 13,
  parameter int DW = 5,
  localparam int CNW = $clog2(NW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic [NW-1:0] quo,
  output logic          done
);
  logic [NW-1:0]  rem;
  logic [NW-1:0]  num_h;
  logic [DW-1:0]  den_h;
  logic [CNW-1:0] cnt;
  logic           run;
  logic [NW:0]    trial;

  assign trial = {rem, quo[NW-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem   <= '0;
      quo   <= '0;
      num_h <= '0;
      den_h <= '0;
      cnt   <= '0;
      run   <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!run) begin
        if (start) begin
          rem   <= '0;
          quo   <= num;
          num_h <= num;
          den_h <= den;
          cnt   <= CNW'(NW);
          run   <= 1'b1;
        end
      end else begin
        if (trial >= (NW+1)'(den_h)) begin
          rem <= NW'(trial - (NW+1)'(den_h));
          quo <= {quo[NW-2:0], 1'b1};
        end else begin
          rem <= NW'(trial);
          quo <= {quo[NW-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CNW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assert_div_exact_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> ((2*NW)'(quo) * (2*NW)'(den_h) + (2*NW)'(rem) == (2*NW)'(num_h)
              && (NW+1)'(rem) < (NW+1)'(den_h)));
endmodule

// File: rtl/pulse_capture.sv
module pulse_capture #(
  parameter int CW = 12,
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gate,
  input  logic [TW-1:0] lead_dec,
  input  logic [TW-1:0] trail_dec,
  output logic [CW-1:0] coarse,
  output logic [TW-1:0] lead_cnt,
  output logic [TW-1:0] trail_cnt
);
  localparam logic [CW-1:0] CMAX = '1;
  logic gate_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q    <= 1'b0;
      coarse    <= '0;
      lead_cnt  <= '0;
      trail_cnt <= '0;
    end else begin
      gate_q <= gate;
      if (gate && !gate_q) begin
        coarse   <= CW'(1);
        lead_cnt <= lead_dec;
      end else if (gate && gate_q && coarse != CMAX) begin
        coarse <= coarse + 1'b1;
      end
      if (!gate && gate_q) trail_cnt <= trail_dec;
    end
  end

  assert_coarse_step_R3: assert property (@(posedge clk) disable iff (rst)
    $past(gate && gate_q && coarse != CMAX) |-> coarse == $past(coarse) + 1'b1);
endmodule

// File: rtl/interval_tdc.sv
module interval_tdc #(
  parameter int TAPS = 16,
  parameter int CW   = 12,
  parameter int FRAC = 8,
  localparam int TW  = $clog2(TAPS + 1),
  localparam int NW  = TW + FRAC,
  localparam int RW  = CW + FRAC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cal_start,
  input  logic            gate,
  input  logic            coarse_done,
  input  logic [TAPS-1:0] lead_taps,
  input  logic [TAPS-1:0] trail_taps,
  output logic            busy,
  output logic            cal_error,
  output logic [RW-1:0]   result,
  output logic            result_valid
);
  import tdc_pkg::*;

  tdc_state_t     state;
  logic [TW-1:0]  lead_dec, trail_dec;
  logic [TW-1:0]  lead_cnt, trail_cnt;
  logic [CW-1:0]  coarse, coarse_snap;
  logic [TW-1:0]  lead_per, trail_per;
  logic [NW-1:0]  lead_frac;
  logic           div_start, div_done;
  logic [NW-1:0]  div_num, div_q;
  logic [TW-1:0]  div_den;
  logic           accept_cal, accept_meas, period_ok;
  logic [RW+1:0]  pos_sum, diff;
  logic [RW-1:0]  res_next;

  therm_count #(.TAPS(TAPS)) u_lead_dec  (.taps(lead_taps),  .count(lead_dec));
  therm_count #(.TAPS(TAPS)) u_trail_dec (.taps(trail_taps), .count(trail_dec));

  pulse_capture #(.CW(CW), .TW(TW)) u_cap (
    .clk(clk), .rst(rst), .gate(gate),
    .lead_dec(lead_dec), .trail_dec(trail_dec),
    .coarse(coarse), .lead_cnt(lead_cnt), .trail_cnt(trail_cnt)
  );

  assign accept_cal  = (state == ST_IDLE) && cal_start;
  assign accept_meas = (state == ST_IDLE) && coarse_done && !cal_start;
  assign period_ok   = (lead_per != '0) && (trail_per != '0);
  assign div_start   = (accept_meas && period_ok) || (state == ST_DIV_L && div_done);
  assign div_num     = (state == ST_DIV_L) ? {trail_cnt, {FRAC{1'b0}}}
                                           : {lead_cnt,  {FRAC{1'b0}}};
  assign div_den     = (state == ST_DIV_L) ? trail_per : lead_per;

  seq_divider #(.NW(NW), .DW(TW)) u_div (
    .clk(clk), .rst(rst), .start(div_start),
    .num(div_num), .den(div_den), .quo(div_q), .done(div_done)
  );

  always_comb begin
    pos_sum = {2'b00, coarse_snap, {FRAC{1'b0}}} + (RW+2)'(lead_frac);
    diff    = pos_sum - (RW+2)'(div_q);
    if (pos_sum < (RW+2)'(div_q))   res_next = '0;
    else if (diff[RW+1:RW] != 2'b0) res_next = '1;
    else                            res_next = diff[RW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      lead_per     <= '0;
      trail_per    <= '0;
      coarse_snap  <= '0;
      lead_frac    <= '0;
      cal_error    <= 1'b0;
      result       <= '0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept_cal) begin
            cal_error <= 1'b0;
            state     <= ST_CAL_L;
          end else if (accept_meas) begin
            if (!period_ok) begin
              cal_error <= 1'b1;
            end else begin
              cal_error   <= 1'b0;
              coarse_snap <= coarse;
              state       <= ST_DIV_L;
            end
          end
        end
        ST_CAL_L: begin
          lead_per <= lead_dec;
          state    <= ST_CAL_T;
        end
        ST_CAL_T: begin
          trail_per <= trail_dec;
          state     <= ST_IDLE;
        end
        ST_DIV_L: begin
          if (div_done) begin
            lead_frac <= div_q;
            state     <= ST_DIV_T;
          end
        end
        ST_DIV_T: begin
          if (div_done) begin
            result       <= res_next;
            result_valid <= 1'b1;
            state        <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);
  assert_err_no_result_R8: assert property (@(posedge clk) disable iff (rst)
    cal_error |-> !result_valid);
  assert_busy_before_valid_R10: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> $past(busy) && !busy);
  assert_periods_held_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DIV_L || state == ST_DIV_T) |=> $stable(lead_per) && $stable(trail_per));
endmodule

// File: tb/interval_tdc_test.sv
module interval_tdc_test;
  localparam int TAPS = 16, CW = 12, FRAC = 8, RW = CW + FRAC;
  localparam int RMAX = (1 << RW) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic cal_start = 0, gate = 0, coarse_done = 0;
  logic [TAPS-1:0] lead_taps = '0, trail_taps = '0;
  logic busy, cal_error, result_valid;
  logic [RW-1:0] result;

  int n_chk = 0, n_fail = 0;
  int cur_lp = 0, cur_tp = 0;
  bit done_flag = 0;

  interval_tdc #(.TAPS(TAPS), .CW(CW), .FRAC(FRAC)) uut (
    .clk(clk), .rst(rst), .cal_start(cal_start), .gate(gate),
    .coarse_done(coarse_done), .lead_taps(lead_taps), .trail_taps(trail_taps),
    .busy(busy), .cal_error(cal_error), .result(result), .result_valid(result_valid)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [TAPS-1:0] therm(input int c, input int noise);
    logic [TAPS-1:0] v;
    if (c >= TAPS) return '1;
    v = TAPS'((1 << c) - 1);
    v = v | (TAPS'(noise) & ~TAPS'((1 << (c + 1)) - 1));
    return v;
  endfunction

  function automatic int expect_res(input int n, input int lc, input int tc);
    int c, r;
    c = (n > (1 << CW) - 1) ? (1 << CW) - 1 : n;
    r = c * 256 + (lc * 256) / cur_lp - (tc * 256) / cur_tp;
    if (r < 0) r = 0;
    if (r > RMAX) r = RMAX;
    return r;
  endfunction

  task automatic calibrate(input int lp, input int tp, input int noise);
    @(negedge clk); cal_start = 1;
    @(negedge clk); cal_start = 0; lead_taps = therm(lp, noise);
    chk(busy == 1'b1, "R5 busy in lead calibration", busy, 1);
    @(negedge clk); trail_taps = therm(tp, noise);
    chk(busy == 1'b1, "R5 busy in trail calibration", busy, 1);
    @(negedge clk);
    chk(busy == 1'b0, "R5 idle after calibration", busy, 0);
    chk(cal_error == 1'b0, "R8 error cleared by calibration", cal_error, 0);
    cur_lp = lp; cur_tp = tp;
  endtask

  // mode 0: normal, 1: poke strobes while busy, 2: expect zero-period error
  task automatic measure(input int n, input int lc, input int tc, input int noise, input int mode);
    int got, vcnt, exp;
    @(negedge clk); gate = 1; lead_taps = therm(lc, noise);
    repeat (n) @(negedge clk);
    gate = 0; trail_taps = therm(tc, noise ^ 16'h5A5A); lead_taps = 16'h00F0;
    @(negedge clk); coarse_done = 1;
    @(negedge clk); coarse_done = 0;
    if (mode == 2) begin
      chk(cal_error == 1'b1, "R8 error on zero period", cal_error, 1);
      chk(busy == 1'b0, "R8 no busy on zero period", busy, 0);
      vcnt = 0;
      repeat (60) begin @(negedge clk); if (result_valid) vcnt++; end
      chk(vcnt == 0, "R8 no result on zero period", vcnt, 0);
      return;
    end
    chk(busy == 1'b1, "R10 busy after accepted request", busy, 1);
    got = -1; vcnt = 0;
    for (int i = 0; i < 100; i++) begin
      if (mode == 1 && i == 3) begin lead_taps = '0; trail_taps = '0; cal_start = 1; coarse_done = 1; end
      if (mode == 1 && i == 4) begin cal_start = 0; coarse_done = 0; end
      if (result_valid) begin
        vcnt++;
        if (got < 0) begin
          got = int'(result);
          chk(busy == 1'b0, "R10 busy low with valid", busy, 0);
        end
      end else if (got >= 0) break;
      @(negedge clk);
    end
    exp = expect_res(n, lc, tc);
    chk(got == exp, (noise != 0) ? "R6 R2 result with bubbles" : "R6 R3 R4 result", got, exp);
    chk(vcnt == 1, "R7 valid single cycle", vcnt, 1);
    @(negedge clk);
    chk(int'(result) == exp, "R7 result held", int'(result), exp);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    int vcnt;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1 busy after reset", busy, 0);
    chk(cal_error == 0, "R1 error after reset", cal_error, 0);
    chk(result_valid == 0, "R1 valid after reset", result_valid, 0);
    chk(result == '0, "R1 result after reset", int'(result), 0);
    // R1 periods reset to zero -> request raises error
    measure(2, 3, 3, 0, 2);

    // R3 R4 R6 sweep over tap counts and calibrations
    for (int p = 0; p < 4; p++) begin
      int lps[4] = '{16, 10, 7, 1};
      int tps[4] = '{16, 13, 3, 5};
      calibrate(lps[p], tps[p], (p == 1) ? 16'hA5A5 : 0);
      for (int lc = 0; lc <= TAPS; lc++)
        for (int tc = 0; tc <= TAPS; tc++)
          measure(1 + (lc + tc + p) % 4, lc, tc, (lc % 3 == 0) ? 16'hC3C3 : 0, 0);
    end

    // R3 coarse saturation and R6 upper clamp
    calibrate(1, 16, 0);
    measure(4100, 16, 0, 0, 0);

    // R8 zero period error, then recovery
    calibrate(0, 7, 0);
    measure(3, 4, 4, 0, 2);
    calibrate(12, 12, 0);
    measure(5, 6, 9, 0, 0);

    // R9 both strobes in the same idle cycle: calibration wins
    @(negedge clk); cal_start = 1; coarse_done = 1;
    @(negedge clk); cal_start = 0; coarse_done = 0; lead_taps = therm(5, 0);
    @(negedge clk); trail_taps = therm(9, 0);
    cur_lp = 5; cur_tp = 9;
    vcnt = 0;
    repeat (60) begin @(negedge clk); if (result_valid) vcnt++; end
    chk(vcnt == 0, "R9 request dropped when calibration wins", vcnt, 0);
    measure(3, 4, 7, 0, 0);

    // R9 strobes while busy are ignored
    measure(2, 11, 2, 0, 1);
    measure(2, 2, 11, 0, 0);

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule